// File: doc/BRIEF.md
# UART Hardware Flow Control (RTS/CTS)

This block supplies the handshake logic that sits between a UART's receive FIFO, its transmit serializer and the two modem-control pins. On the receive side it compares the current FIFO fill level with one of four selectable trigger points. It drives an active-low request-to-send pin with hysteresis. The pin is released (driven high) when the fill level reaches the trigger point. It is driven low again only once the FIFO has drained to the next lower trigger point. When automatic RTS is disabled, a software control bit drives the pin instead.

On the transmit side, an active-low clear-to-send input passes through a synchronizer. When automatic CTS is enabled, this input decides whether the serializer may begin its next character. A character already on the line always runs to completion; only the next start is held back. The FIFO, the serializer and deserializer, the baud generator and the register interface are outside this block. The block only sees fill levels, request and busy strobes, and a write strobe with data for the control bit.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rts_n` is 1 (de-asserted), `rts_ctrl_rd` is 0 and `tx_start` is 0.
- R2: With `rts_auto_en` = 0, a cycle with `rts_ctrl_wr` = 1 loads `rts_ctrl_wdata` into the control bit at that clock edge. From the same edge onward, `rts_n` equals the inverse of the control bit, and `rx_level` has no effect on `rts_n`.
- R3: `trig_sel` encodes the trigger point as 0→1, 1→4, 2→8, 3→14 entries. With `rts_auto_en` = 1, a cycle with `rx_level` ≥ the trigger point makes `rts_n` = 1 after the next clock edge.
- R4: The lower point paired with each trigger is 0, 1, 4, 8 for `trig_sel` 0, 1, 2, 3. With `rts_auto_en` = 1, a cycle with `rx_level` ≤ the lower point makes `rts_n` = 0 after the next clock edge.
- R5: With `rts_auto_en` = 1 and `rx_level` strictly between the lower point and the trigger point, `rts_n` keeps its previous value. A level above the trigger point (a byte that arrives after release) keeps `rts_n` at 1.
- R6: With `rts_auto_en` = 1, `rts_ctrl_rd` reads 1 while `rts_n` is 0 and 0 while `rts_n` is 1. Writes through `rts_ctrl_wr` do not change it.
- R7: With `cts_auto_en` = 1, `tx_start` is raised only while the synchronized `cts_n` is 0. With `cts_auto_en` = 0, `cts_n` has no effect on `tx_start`.
- R8: `cts_n` passes through `SYNC_STAGES` flip-flops before use. With the default of 2, a change of `cts_n` first affects `tx_start` after the third rising edge.
- R9: `tx_start` is a one-cycle pulse, raised only when `tx_req` = 1 and `tx_busy` = 0. A de-assertion of CTS while `tx_busy` = 1 does not end the character, and the next start waits for CTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rts_auto_en | input | 1 | Enables automatic RTS from FIFO level |
| cts_auto_en | input | 1 | Enables CTS gating of transmit starts |
| trig_sel | input | 2 | Trigger point select (0:1, 1:4, 2:8, 3:14) |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| rts_ctrl_wr | input | 1 | Write strobe for the RTS control bit |
| rts_ctrl_wdata | input | 1 | Value written to the RTS control bit (1 = assert) |
| rts_ctrl_rd | output | 1 | Readable RTS control bit / pin mirror |
| rts_n | output | 1 | Active-low request-to-send pin |
| cts_n | input | 1 | Active-low clear-to-send pin (asynchronous) |
| tx_req | input | 1 | Serializer has a character ready |
| tx_busy | input | 1 | Serializer is shifting a character |
| tx_start | output | 1 | One-cycle permission to start a character |

## Verification
The bench uses the default `FIFO_DEPTH` of 16, which gives a 5-bit level port. Levels of 15 and 16 can therefore be driven above the highest trigger point of 14, which exercises the extra byte that follows release. With `SYNC_STAGES` at 2, the three-edge CTS latency is an exact boundary to sample on. The vector table walks all four trigger selections and crosses each hysteresis band in both directions. The directed part covers the manual mode, ignored writes in automatic mode, and a CTS drop in the middle of a busy character.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } trig_sel_e;

  // Upper (release) point for a trigger selection.
  function automatic int unsigned trig_hi(trig_sel_e sel);
    case (sel)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction

  // Lower (reassert) point: the next smaller trigger, or empty.
  function automatic int unsigned trig_lo(trig_sel_e sel);
    case (sel)
      TRIG_1:  return 0;
      TRIG_4:  return 1;
      TRIG_8:  return 4;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
  parameter int  STAGES    = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) shreg <= RST_VAL;
        else     shreg <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) shreg <= {STAGES{RST_VAL}};
        else     shreg <= {shreg[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = shreg[STAGES-1];

endmodule

// File: rtl/uart_fc_rts.sv
module uart_fc_rts
  import uart_fc_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_en,
  input  trig_sel_e        sel,
  input  logic [LVL_W-1:0] level,
  input  logic             wr,
  input  logic             wdata,
  output logic             rts_n,
  output logic             ctrl_q
);

  int unsigned lvl;
  logic        at_hi, at_lo;
  logic        rts_n_d, ctrl_d;

  always_comb begin
    lvl   = 32'(level);
    at_hi = (lvl >= trig_hi(sel));
    at_lo = (lvl <= trig_lo(sel));
    if (auto_en) begin
      if (at_hi)      rts_n_d = 1'b1;
      else if (at_lo) rts_n_d = 1'b0;
      else            rts_n_d = rts_n;
      ctrl_d = ~rts_n_d;                 // bit mirrors the pin
    end else begin
      ctrl_d  = wr ? wdata : ctrl_q;
      rts_n_d = ~ctrl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n  <= 1'b1;
      ctrl_q <= 1'b0;
    end else begin
      rts_n  <= rts_n_d;
      ctrl_q <= ctrl_d;
    end
  end

  AST_RTS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (auto_en && at_hi) |=> rts_n);                                   // R3
  AST_RTS_REASSERT: assert property (@(posedge clk) disable iff (rst)
    (auto_en && at_lo) |=> !rts_n);                                  // R4
  AST_RTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (auto_en && !at_hi && !at_lo) |=> $stable(rts_n));               // R5
  AST_AUTO_MIRROR: assert property (@(posedge clk) disable iff (rst)
    auto_en |=> (ctrl_q == !rts_n));                                 // R6
  AST_MANUAL_PIN: assert property (@(posedge clk) disable iff (rst)
    (!auto_en && wr) |=> (ctrl_q == $past(wdata)) && (rts_n == !ctrl_q)); // R2

endmodule

// File: rtl/uart_fc_txgate.sv
module uart_fc_txgate (
  input  logic clk,
  input  logic rst,
  input  logic auto_en,
  input  logic cts_n_s,
  input  logic req,
  input  logic busy,
  output logic start
);

  logic clear;

  assign clear = !auto_en || !cts_n_s;

  always_ff @(posedge clk) begin
    if (rst) start <= 1'b0;
    else     start <= req && !busy && !start && clear;
  end

  AST_CTS_GATE: assert property (@(posedge clk) disable iff (rst)
    (auto_en && cts_n_s) |=> !start);                                // R7
  AST_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy || !req) |=> !start);                                      // R9
  AST_PULSE: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);                                               // R9

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import uart_fc_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rts_auto_en,
  input  logic             cts_auto_en,
  input  logic [1:0]       trig_sel,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rts_ctrl_wr,
  input  logic             rts_ctrl_wdata,
  output logic             rts_ctrl_rd,
  output logic             rts_n,
  input  logic             cts_n,
  input  logic             tx_req,
  input  logic             tx_busy,
  output logic             tx_start
);

  logic cts_n_s;

  uart_fc_rts #(.LVL_W(LVL_W)) u_rts (
    .clk     (clk),
    .rst     (rst),
    .auto_en (rts_auto_en),
    .sel     (trig_sel_e'(trig_sel)),
    .level   (rx_level),
    .wr      (rts_ctrl_wr),
    .wdata   (rts_ctrl_wdata),
    .rts_n   (rts_n),
    .ctrl_q  (rts_ctrl_rd)
  );

  uart_fc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (cts_n),
    .dout (cts_n_s)
  );

  uart_fc_txgate u_txgate (
    .clk     (clk),
    .rst     (rst),
    .auto_en (cts_auto_en),
    .cts_n_s (cts_n_s),
    .req     (tx_req),
    .busy    (tx_busy),
    .start   (tx_start)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (rts_n && !rts_ctrl_rd && !tx_start));                   // R1

endmodule

// File: tb/uart_flow_ctrl_tb.sv
module uart_flow_ctrl_tb;

  localparam int LVL_W = 5;
  localparam int NV    = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rts_auto_en = 0, cts_auto_en = 0;
  logic [1:0] trig_sel = 0;
  logic [LVL_W-1:0] rx_level = 0;
  logic rts_ctrl_wr = 0, rts_ctrl_wdata = 0;
  logic rts_ctrl_rd, rts_n, tx_start;
  logic cts_n = 1, tx_req = 0, tx_busy = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_flow_ctrl u_dut (
    .clk(clk), .rst(rst), .rts_auto_en(rts_auto_en), .cts_auto_en(cts_auto_en),
    .trig_sel(trig_sel), .rx_level(rx_level), .rts_ctrl_wr(rts_ctrl_wr),
    .rts_ctrl_wdata(rts_ctrl_wdata), .rts_ctrl_rd(rts_ctrl_rd), .rts_n(rts_n),
    .cts_n(cts_n), .tx_req(tx_req), .tx_busy(tx_busy), .tx_start(tx_start)
  );

  // {trig_sel, rx_level, expected rts_n}
  localparam logic [7:0] VEC [NV] = '{
    {2'd2, 5'd0,  1'b0}, {2'd2, 5'd7,  1'b0}, {2'd2, 5'd8,  1'b1},
    {2'd2, 5'd9,  1'b1}, {2'd2, 5'd6,  1'b1}, {2'd2, 5'd5,  1'b1},
    {2'd2, 5'd4,  1'b0}, {2'd2, 5'd7,  1'b0}, {2'd0, 5'd1,  1'b1},
    {2'd0, 5'd0,  1'b0}, {2'd3, 5'd13, 1'b0}, {2'd3, 5'd16, 1'b1},
    {2'd3, 5'd9,  1'b1}, {2'd3, 5'd8,  1'b0}, {2'd1, 5'd4,  1'b1},
    {2'd1, 5'd2,  1'b1}, {2'd1, 5'd1,  1'b0}, {2'd1, 5'd3,  1'b0}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    check("R1 rts_n in reset", rts_n, 1'b1);
    check("R1 ctrl in reset", rts_ctrl_rd, 1'b0);
    check("R1 tx_start in reset", tx_start, 1'b0);
    rst = 0;
    step();
    check("R1 rts_n after reset", rts_n, 1'b1);
    check("R1 ctrl after reset", rts_ctrl_rd, 1'b0);

    // Table walk: automatic RTS hysteresis (R3 R4 R5 R6)
    rts_auto_en = 1;
    for (int i = 0; i < NV; i++) begin
      trig_sel = VEC[i][7:6];
      rx_level = VEC[i][5:1];
      step();
      check("R3/R4/R5 rts_n vector", rts_n, VEC[i][0]);
      check("R6 ctrl mirror vector", rts_ctrl_rd, !VEC[i][0]);
    end

    // R6: writes ignored in automatic mode
    rx_level = 0; trig_sel = 0;
    step();
    rts_ctrl_wr = 1; rts_ctrl_wdata = 0;
    step();
    check("R6 ctrl ignores write 0", rts_ctrl_rd, 1'b1);
    check("R6 pin ignores write 0", rts_n, 1'b0);
    trig_sel = 3; rx_level = 14; rts_ctrl_wdata = 1;
    step();
    check("R6 ctrl ignores write 1", rts_ctrl_rd, 1'b0);
    check("R3 release at 14", rts_n, 1'b1);
    rts_ctrl_wr = 0;

    // R2: manual mode
    rts_auto_en = 0;
    rts_ctrl_wr = 1; rts_ctrl_wdata = 1;
    step();
    rts_ctrl_wr = 0;
    check("R2 pin after write 1", rts_n, 1'b0);
    check("R2 ctrl after write 1", rts_ctrl_rd, 1'b1);
    trig_sel = 0; rx_level = 16;
    step(); step();
    check("R2 level ignored", rts_n, 1'b0);
    rts_ctrl_wr = 1; rts_ctrl_wdata = 0;
    step();
    rts_ctrl_wr = 0;
    check("R2 pin after write 0", rts_n, 1'b1);
    rx_level = 0;
    step(); step();
    check("R2 level 0 ignored", rts_n, 1'b1);

    // R7/R8/R9: CTS gating
    cts_auto_en = 1; cts_n = 1; tx_req = 1; tx_busy = 0;
    for (int k = 0; k < 5; k++) begin
      step();
      check("R7 blocked while cts high", tx_start, 1'b0);
    end
    cts_n = 0;
    step();
    check("R8 latency edge 1", tx_start, 1'b0);
    step();
    check("R8 latency edge 2", tx_start, 1'b0);
    step();
    check("R8 start on edge 3", tx_start, 1'b1);
    tx_busy = 1;
    step();
    check("R9 single pulse", tx_start, 1'b0);
    cts_n = 1;
    for (int k = 0; k < 4; k++) begin
      step();
      check("R9 no start while busy", tx_start, 1'b0);
    end
    tx_busy = 0;
    step();
    check("R9 next char waits for cts", tx_start, 1'b0);
    step();
    check("R7 still waiting", tx_start, 1'b0);
    cts_n = 0;
    step(); step(); step();
    check("R7 start after cts low", tx_start, 1'b1);
    tx_busy = 1;
    step();
    tx_busy = 0; cts_auto_en = 0; cts_n = 1;
    step();
    check("R7 cts ignored when off", tx_start, 1'b1);
    tx_req = 0;
    step();
    check("R9 no start without req", tx_start, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule